// File: doc/BRIEF.md
# Decimating FIR control sequencer

This block steers one channel of a polyphase decimating FIR filter. The filter's coefficients are held in a shared 256-word coefficient RAM. A small register interface sets four values: the decimation factor M, the polyphase start phase, the tap count N and the coefficient offset. The host loads coefficients through a 128-word window, and a bank bit picks which half of the RAM that window reaches. Each accepted input sample is written into a circular sample buffer. After every M samples the block runs one computation. In that computation it issues N pairs of read addresses, one into the coefficient RAM and one into the sample buffer. It raises a clear strobe with the first tap and an output strobe after the last tap. The multiply-accumulate unit sits outside the block.

A control register selects the input. The channel can take its own upstream stream or a neighbouring channel's stream, which lets filters be cascaded. The same register holds a bypass bit. In bypass the filter does not run, and the top 16 bits of each selected sample are latched into a readback register.

The FSM has three states:
- `ST_IDLE` waits for a trigger. A trigger is a sample accepted while the sample counter equals M-1 and bypass is off.
- `ST_RUN` steps the tap index from 0 to N-1. `ST_RUN` stays in `ST_RUN` until tap N-1, then moves to `ST_DONE`.
- `ST_DONE` lasts one cycle and pulses the output strobe. `ST_DONE` always returns to `ST_IDLE`.

On the `ST_IDLE` to `ST_RUN` edge the block latches three things: the coefficient offset from its shadow, the newest buffer index, and the reload value of the sample counter.

Top module: `fir_dec_seq`

## Requirements
- R1: After reset all registers are zero, which gives M=1, N=1, offset 0, phase 0, bank 0, own input and bypass off. The strobes are low, `buf_waddr` is 0 and `byp_data` is 0.
- R2: An output computation starts on every M-th accepted sample, where M = decimation register (address 0) + 1. The first computation after reset starts on the M-th sample.
- R3: Starting the cycle after the triggering sample's clock edge, `acc_en` is high for exactly N cycles, where N = tap register (address 2) + 1. `acc_clr` is high only in the first of those cycles. `out_valid` is high for the single cycle that follows them.
- R4: During tap t the coefficient read address is (working offset + t) mod 256.
- R5: Accepted samples are written to buffer addresses 0, 1, 2 and so on after reset, wrapping at 256. During tap t the buffer read address is (index of the triggering sample − t) mod 256.
- R6: A write to the offset register (address 3) only updates a shadow. The working offset is copied from the shadow when a computation starts, so a write made during a computation does not change that computation's addresses.
- R7: When a computation starts, the sample counter is reloaded with (phase register (address 1) mod M). The next computation therefore starts after M − (phase mod M) further samples.
- R8: A host coefficient write at window address a drives `cram_waddr` = {bank, a}. The bank is bit 0 of the control register (address 4).
- R9: When control bit 2 (bypass) is 1, no computation starts. Each accepted sample's top 16 bits appear on `byp_data` one cycle after it is accepted.
- R10: Control bit 1 selects the input: 0 takes `own_valid`/`own_data`, 1 takes `alt_valid`/`alt_data`. The selected input feeds the buffer, the sample counter and `byp_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select: 0 decim−1, 1 phase, 2 taps−1, 3 offset, 4 control |
| cfg_wdata | input | CFG_W | Register write data |
| hc_we | input | 1 | Host coefficient write strobe |
| hc_addr | input | CADDR_W−1 | Host coefficient window address |
| hc_wdata | input | COEF_W | Host coefficient data |
| cram_we | output | 1 | Coefficient RAM write enable |
| cram_waddr | output | CADDR_W | Coefficient RAM write address |
| cram_wdata | output | COEF_W | Coefficient RAM write data |
| own_valid | input | 1 | Own-channel sample strobe |
| own_data | input | DATA_W | Own-channel sample |
| alt_valid | input | 1 | Neighbour-channel sample strobe |
| alt_data | input | DATA_W | Neighbour-channel sample |
| buf_we | output | 1 | Sample buffer write enable |
| buf_waddr | output | BADDR_W | Sample buffer write address |
| buf_wdata | output | DATA_W | Sample buffer write data |
| coef_raddr | output | CADDR_W | Coefficient RAM read address |
| buf_raddr | output | BADDR_W | Sample buffer read address |
| acc_en | output | 1 | Accumulate this tap |
| acc_clr | output | 1 | Start a new sum with this tap |
| out_valid | output | 1 | Accumulated result is complete |
| byp_data | output | BYP_W | Bypass readback of the top bits of the latest sample |

## Verification
Say a triggering sample is taken at edge k. The tap addresses and strobes are due in the N cycles after edge k, and `out_valid` is due in the cycle after those. `byp_data` and the buffer write pointer change one cycle after the accepting edge, and the host write address is combinational. The bench drives on falling edges and samples on the next falling edge or later, so each result is read once its register has settled. A behavioural MAC reads the bench's own memories through the address outputs, and every `out_valid` result is compared against a sum that a bench model computes from the samples and coefficients it supplied.

// File: rtl/fsq_pkg.sv
package fsq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } fsq_state_t;

    localparam logic [2:0] REG_DECIM  = 3'd0;
    localparam logic [2:0] REG_PHASE  = 3'd1;
    localparam logic [2:0] REG_TAPS   = 3'd2;
    localparam logic [2:0] REG_OFFSET = 3'd3;
    localparam logic [2:0] REG_CTRL   = 3'd4;

    localparam int CTL_BANK = 0;
    localparam int CTL_SRC  = 1;
    localparam int CTL_BYP  = 2;
    localparam int CTL_W    = 3;
endpackage

// File: rtl/fsq_host_regs.sv
module fsq_host_regs
    import fsq_pkg::*;
#(
    parameter int CFG_W   = 8,
    parameter int DEC_W   = 8,
    parameter int CADDR_W = 8,
    parameter int COEF_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [2:0]         cfg_addr,
    input  logic [CFG_W-1:0]   cfg_wdata,
    input  logic               hc_we,
    input  logic [CADDR_W-2:0] hc_addr,
    input  logic [COEF_W-1:0]  hc_wdata,
    input  logic               start,
    output logic [DEC_W-1:0]   decim_m1,
    output logic [DEC_W-1:0]   phase,
    output logic [CADDR_W-1:0] taps_m1,
    output logic [CADDR_W-1:0] work_off,
    output logic               ctl_src,
    output logic               ctl_byp,
    output logic               cram_we,
    output logic [CADDR_W-1:0] cram_waddr,
    output logic [COEF_W-1:0]  cram_wdata
);
    logic [CADDR_W-1:0] off_shadow;
    logic [CTL_W-1:0]   ctl;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            decim_m1   <= '0;
            phase      <= '0;
            taps_m1    <= '0;
            off_shadow <= '0;
            ctl        <= '0;
        end else if (cfg_we) begin
            unique case (cfg_addr)
                REG_DECIM:  decim_m1   <= cfg_wdata[DEC_W-1:0];
                REG_PHASE:  phase      <= cfg_wdata[DEC_W-1:0];
                REG_TAPS:   taps_m1    <= cfg_wdata[CADDR_W-1:0];
                REG_OFFSET: off_shadow <= cfg_wdata[CADDR_W-1:0];
                REG_CTRL:   ctl        <= cfg_wdata[CTL_W-1:0];
                default:    ;
            endcase
        end
    end

    // Working pointer moves only on a computation boundary
    always_ff @(posedge clk) begin
        if (!rst_n)     work_off <= '0;
        else if (start) work_off <= off_shadow;
    end

    assign ctl_src    = ctl[CTL_SRC];
    assign ctl_byp    = ctl[CTL_BYP];
    assign cram_we    = hc_we;
    assign cram_waddr = {ctl[CTL_BANK], hc_addr};
    assign cram_wdata = hc_wdata;
endmodule

// File: rtl/fsq_in_ctrl.sv
module fsq_in_ctrl #(
    parameter int DATA_W  = 24,
    parameter int DEC_W   = 8,
    parameter int BADDR_W = 8,
    parameter int BYP_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               own_valid,
    input  logic [DATA_W-1:0]  own_data,
    input  logic               alt_valid,
    input  logic [DATA_W-1:0]  alt_data,
    input  logic               ctl_src,
    input  logic               ctl_byp,
    input  logic [DEC_W-1:0]   decim_m1,
    input  logic [DEC_W-1:0]   phase,
    input  logic               start,
    output logic               trig,
    output logic               buf_we,
    output logic [BADDR_W-1:0] buf_waddr,
    output logic [DATA_W-1:0]  buf_wdata,
    output logic [BYP_W-1:0]   byp_data
);
    localparam int M_W = DEC_W + 1;

    logic [DEC_W-1:0] cnt;
    logic [M_W-1:0]   m_full;
    logic [M_W-1:0]   phase_red;

    assign buf_we    = ctl_src ? alt_valid : own_valid;
    assign buf_wdata = ctl_src ? alt_data  : own_data;
    assign trig      = buf_we && !ctl_byp && (cnt == decim_m1);

    assign m_full    = {1'b0, decim_m1} + M_W'(1);
    assign phase_red = {1'b0, phase} % m_full;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            buf_waddr <= '0;
            byp_data  <= '0;
        end else if (buf_we) begin
            buf_waddr <= buf_waddr + BADDR_W'(1);
            if (start)                 cnt <= phase_red[DEC_W-1:0];
            else if (cnt == decim_m1)  cnt <= '0;
            else                       cnt <= cnt + DEC_W'(1);
            if (ctl_byp)               byp_data <= buf_wdata[DATA_W-1 -: BYP_W];
        end
    end
endmodule

// File: rtl/fsq_tap_fsm.sv
module fsq_tap_fsm
    import fsq_pkg::*;
#(
    parameter int CADDR_W = 8,
    parameter int BADDR_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               trig,
    input  logic [CADDR_W-1:0] taps_m1,
    input  logic [CADDR_W-1:0] work_off,
    input  logic [BADDR_W-1:0] newest,
    output logic               start,
    output logic [CADDR_W-1:0] coef_raddr,
    output logic [BADDR_W-1:0] buf_raddr,
    output logic               acc_en,
    output logic               acc_clr,
    output logic               out_valid
);
    fsq_state_t         state, state_nx;
    logic [CADDR_W-1:0] tap;
    logic [BADDR_W-1:0] base;
    logic               last_tap;

    assign start    = (state == ST_IDLE) && trig;
    assign last_tap = (tap == taps_m1);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tap  <= '0;
            base <= '0;
        end else if (start) begin
            tap  <= '0;
            base <= newest;
        end else if (state == ST_RUN) begin
            tap  <= tap + CADDR_W'(1);
        end
    end

    always_comb begin
        state_nx   = state;
        acc_en     = 1'b0;
        acc_clr    = 1'b0;
        out_valid  = 1'b0;
        coef_raddr = work_off + tap;
        buf_raddr  = base - BADDR_W'(tap);
        unique case (state)
            ST_IDLE: if (trig) state_nx = ST_RUN;
            ST_RUN: begin
                acc_en  = 1'b1;
                acc_clr = (tap == '0);
                if (last_tap) state_nx = ST_DONE;
            end
            ST_DONE: begin
                out_valid = 1'b1;
                state_nx  = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/fir_dec_seq.sv
module fir_dec_seq #(
    parameter int DATA_W  = 24,
    parameter int COEF_W  = 16,
    parameter int CADDR_W = 8,
    parameter int BADDR_W = 8,
    parameter int DEC_W   = 8,
    parameter int CFG_W   = 8,
    parameter int BYP_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [2:0]         cfg_addr,
    input  logic [CFG_W-1:0]   cfg_wdata,
    input  logic               hc_we,
    input  logic [CADDR_W-2:0] hc_addr,
    input  logic [COEF_W-1:0]  hc_wdata,
    output logic               cram_we,
    output logic [CADDR_W-1:0] cram_waddr,
    output logic [COEF_W-1:0]  cram_wdata,
    input  logic               own_valid,
    input  logic [DATA_W-1:0]  own_data,
    input  logic               alt_valid,
    input  logic [DATA_W-1:0]  alt_data,
    output logic               buf_we,
    output logic [BADDR_W-1:0] buf_waddr,
    output logic [DATA_W-1:0]  buf_wdata,
    output logic [CADDR_W-1:0] coef_raddr,
    output logic [BADDR_W-1:0] buf_raddr,
    output logic               acc_en,
    output logic               acc_clr,
    output logic               out_valid,
    output logic [BYP_W-1:0]   byp_data
);
    logic [DEC_W-1:0]   decim_m1, phase;
    logic [CADDR_W-1:0] taps_m1, work_off;
    logic               ctl_src, ctl_byp, start, trig;

    fsq_host_regs #(.CFG_W(CFG_W), .DEC_W(DEC_W), .CADDR_W(CADDR_W), .COEF_W(COEF_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .hc_we(hc_we), .hc_addr(hc_addr), .hc_wdata(hc_wdata), .start(start),
        .decim_m1(decim_m1), .phase(phase), .taps_m1(taps_m1), .work_off(work_off),
        .ctl_src(ctl_src), .ctl_byp(ctl_byp),
        .cram_we(cram_we), .cram_waddr(cram_waddr), .cram_wdata(cram_wdata)
    );

    fsq_in_ctrl #(.DATA_W(DATA_W), .DEC_W(DEC_W), .BADDR_W(BADDR_W), .BYP_W(BYP_W)) u_in (
        .clk(clk), .rst_n(rst_n), .own_valid(own_valid), .own_data(own_data),
        .alt_valid(alt_valid), .alt_data(alt_data), .ctl_src(ctl_src), .ctl_byp(ctl_byp),
        .decim_m1(decim_m1), .phase(phase), .start(start), .trig(trig),
        .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata), .byp_data(byp_data)
    );

    fsq_tap_fsm #(.CADDR_W(CADDR_W), .BADDR_W(BADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .trig(trig), .taps_m1(taps_m1), .work_off(work_off),
        .newest(buf_waddr), .start(start), .coef_raddr(coef_raddr), .buf_raddr(buf_raddr),
        .acc_en(acc_en), .acc_clr(acc_clr), .out_valid(out_valid)
    );
endmodule

// File: rtl/fsq_checker.sv
module fsq_checker #(
    parameter int CADDR_W = 8,
    parameter int BADDR_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               acc_en,
    input logic               acc_clr,
    input logic               out_valid,
    input logic               ctl_byp,
    input logic [CADDR_W-1:0] coef_raddr,
    input logic [BADDR_W-1:0] buf_raddr
);
    // R3: result strobe is a single-cycle pulse
    a_r3_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R3: result strobe follows an accumulate cycle
    a_r3_valid_after_tap: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(acc_en));

    // R3: clear only accompanies an accumulate
    a_r3_clr_with_en: assert property (@(posedge clk) disable iff (!rst_n)
        acc_clr |-> acc_en);

    // R4: coefficient address advances by one per tap
    a_r4_coef_step: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_clr) |-> (coef_raddr == $past(coef_raddr) + CADDR_W'(1)));

    // R5: buffer address walks back one sample per tap
    a_r5_buf_step: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_clr) |-> (buf_raddr == $past(buf_raddr) - BADDR_W'(1)));

    // R9: an idle filter stays idle while bypassed
    a_r9_bypass_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_byp && !acc_en && !out_valid) |=> !acc_en);
endmodule

bind fir_dec_seq fsq_checker #(.CADDR_W(CADDR_W), .BADDR_W(BADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_clr(acc_clr), .out_valid(out_valid),
    .ctl_byp(ctl_byp), .coef_raddr(coef_raddr), .buf_raddr(buf_raddr)
);

// File: tb/fir_dec_seq_tb.sv
module fir_dec_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        hc_we = 1'b0;
    logic [6:0]  hc_addr = '0;
    logic [15:0] hc_wdata = '0;
    logic        cram_we;
    logic [7:0]  cram_waddr;
    logic [15:0] cram_wdata;
    logic        own_valid = 1'b0, alt_valid = 1'b0;
    logic [23:0] own_data = '0, alt_data = '0;
    logic        buf_we;
    logic [7:0]  buf_waddr, coef_raddr, buf_raddr;
    logic [23:0] buf_wdata;
    logic        acc_en, acc_clr, out_valid;
    logic [15:0] byp_data;

    always #5 clk = ~clk;

    fir_dec_seq u_dut (.*);

    // behavioural memories and MAC
    logic [15:0] cram [256];
    logic [23:0] bmem [256];
    longint      acc = 0;
    initial for (int i = 0; i < 256; i++) begin cram[i] = '0; bmem[i] = '0; end
    always @(posedge clk) begin
        if (cram_we) cram[cram_waddr] <= cram_wdata;
        if (buf_we)  bmem[buf_waddr]  <= buf_wdata;
        if (acc_en)  acc <= (acc_clr ? 64'sd0 : acc)
                            + longint'(cram[coef_raddr]) * longint'(bmem[buf_raddr]);
    end

    int tests = 0, fails = 0;
    bit done = 0;
    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask
    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    // reference model state
    int hist [256];
    int mcnt, mwidx, mdec, mtaps, mshadow, mph;
    bit mbyp, msrc;
    longint expq [512];
    int ewr = 0, erd = 0, nout = 0, en_cycles = 0;
    initial for (int i = 0; i < 256; i++) hist[i] = 0;

    function automatic int coefv(input int i);
        return (i * 7 + 3) % 97;
    endfunction

    task automatic model_accept(input int v);
        int idx;
        longint e;
        idx = mwidx;
        hist[idx] = v;
        mwidx = (mwidx + 1) & 255;
        if (!mbyp && mcnt == mdec) begin
            e = 0;
            for (int t = 0; t <= mtaps; t++)
                e += longint'(coefv((mshadow + t) & 255)) * longint'(hist[(idx - t) & 255]);
            expq[ewr] = e;
            ewr++;
            mcnt = mph % (mdec + 1);
        end else if (mcnt == mdec) mcnt = 0;
        else mcnt++;
    endtask

    // monitor: every result is compared with the model (R2 R3 R4 R5)
    always @(negedge clk) begin
        if (acc_en) en_cycles++;
        if (out_valid) begin
            nout++;
            if (erd >= ewr) chk(0, "R2 unexpected output", acc, -1);
            else begin
                chk(acc == expq[erd], "R4/R5 filter result", acc, expq[erd]);
                erd++;
            end
        end
    end

    // all tasks enter and leave at a falling edge
    task automatic do_reset();
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        mcnt = 0; mwidx = 0; mdec = 0; mtaps = 0; mshadow = 0; mph = 0; mbyp = 0; msrc = 0;
        erd = ewr;
    endtask
    task automatic wcfg(input int a, input int v);
        cfg_we = 1; cfg_addr = 3'(a); cfg_wdata = 8'(v);
        @(posedge clk);
        case (a)
            0: mdec = v;
            1: mph = v;
            2: mtaps = v;
            3: mshadow = v;
            default: begin msrc = v[1]; mbyp = v[2]; end
        endcase
        @(negedge clk);
        cfg_we = 0;
    endtask
    task automatic wcoef(input int i);
        hc_we = 1; hc_addr = 7'(i); hc_wdata = 16'(coefv(i));
        #1;
        if (i == 5 || i == 133) chk(cram_waddr == 8'(i), "R8 window address", cram_waddr, i);
        @(negedge clk);
        hc_we = 0;
    endtask
    task automatic send(input int d, input int gap);
        own_valid = 1; alt_valid = 1; own_data = 24'(d); alt_data = 24'(d + 500);
        @(posedge clk);
        model_accept(msrc ? d + 500 : d);
        @(negedge clk);
        own_valid = 0; alt_valid = 0;
        repeat (gap) @(negedge clk);
    endtask

    // decim-1, taps-1, offset, phase, samples, expected outputs
    localparam int NV = 5;
    localparam int VEC [NV][6] = '{
        '{3, 3,   0, 0, 20, 5},
        '{0, 0,   5, 0,  6, 6},
        '{4, 7, 250, 2, 24, 7},
        '{2, 4, 130, 7, 18, 8},
        '{7, 15, 60, 0, 40, 5}
    };

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int n0, e0;
        @(negedge clk);
        do_reset();
        // R1 reset state
        chk(!out_valid && !acc_en && !acc_clr, "R1 strobes low", {acc_en, out_valid}, 0);
        chk(buf_waddr == 0, "R1 write pointer", buf_waddr, 0);
        chk(byp_data == 0, "R1 bypass readback", byp_data, 0);
        // coefficient load through the window, bank 0 then bank 1 (R8)
        for (int i = 0; i < 256; i++) begin
            if (i == 0)   wcfg(4, 0);
            if (i == 128) wcfg(4, 1);
            wcoef(i);
        end
        // R1 defaults give M=1, N=1, offset 0
        do_reset();
        n0 = nout;
        send(5, 4);
        send(9, 4);
        chk(nout - n0 == 2, "R1 default decimation", nout - n0, 2);

        // vector table: R2 R4 R5 R7
        for (int v = 0; v < NV; v++) begin
            do_reset();
            wcfg(0, VEC[v][0]); wcfg(2, VEC[v][1]); wcfg(3, VEC[v][2]); wcfg(1, VEC[v][3]);
            n0 = nout;
            for (int s = 0; s < VEC[v][4]; s++) send((s * 37 + v * 11 + 1) % 1000, VEC[v][1] + 4);
            repeat (3) @(negedge clk);
            chk(nout - n0 == VEC[v][5], "R2/R7 output count", nout - n0, VEC[v][5]);
        end

        // R3 R4 R5 R6: first-tap addresses and shadowed offset
        do_reset();
        wcfg(0, 1); wcfg(2, 3); wcfg(3, 10);
        n0 = nout;
        send(1, 6);
        send(2, 0);
        chk(coef_raddr == 10, "R4 first coef address", coef_raddr, 10);
        chk(buf_raddr == 1, "R5 first buffer address", buf_raddr, 1);
        chk(acc_clr && acc_en, "R3 clear on first tap", {acc_clr, acc_en}, 3);
        wcfg(3, 200);
        chk(coef_raddr == 11, "R6 offset held mid-run", coef_raddr, 11);
        repeat (6) @(negedge clk);
        send(3, 6);
        send(4, 0);
        chk(coef_raddr == 200, "R6 new offset at start", coef_raddr, 200);
        repeat (8) @(negedge clk);
        chk(nout - n0 == 2, "R6 output count", nout - n0, 2);

        // R9 R10: bypass and source select
        do_reset();
        wcfg(4, 4);
        n0 = nout; e0 = en_cycles;
        send(24'hABCDEF, 4);
        chk(byp_data == 16'hABCD, "R9 bypass readback", byp_data, 16'hABCD);
        wcfg(4, 6);
        send(24'hABCDEF, 4);
        chk(byp_data == 16'hABCF, "R10 alt source readback", byp_data, 16'hABCF);
        chk(nout == n0 && en_cycles == e0, "R9 filter idle in bypass", en_cycles - e0, 0);
        wcfg(4, 2);
        send(7, 6);
        chk(nout - n0 == 1, "R10 alt source computes", nout - n0, 1);
        chk(byp_data == 16'hABCF, "R9 readback held without bypass", byp_data, 16'hABCF);
        chk(erd == ewr, "R2 no missing outputs", ewr - erd, 0);
        finish_run();
    end
endmodule